// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing front end of a small byte-addressed nonvolatile memory. It watches the SCL and SDA lines with a faster system clock and recognises start and stop conditions. Bytes are shifted in and out most significant bit first. The block acknowledges bytes it accepts and answers only when the device-type code and the three select pins match the address byte. It keeps an address counter that survives from one transfer to the next. Data bytes written by the bus master go to an external program buffer, one strobe per byte. A commit pulse at the closing stop tells the buffer to start its program cycle. While the buffer reports busy, the block stays silent on its own address byte, so a master can poll until the cycle ends.

Read data comes from the memory array over a combinational port: `rd_addr` always shows the counter, and `rd_data` must return that byte in the same cycle. SDA is modelled as an open-drain enable: when `sda_oe` is high the pad pulls the line low, and otherwise the line floats high.

Top module: `tws_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins a new address byte from any state. A stop condition (SDA rising while SCL is high) returns the block to idle with `sda_oe` low.
- R2: The address byte holds the device code 4'b1010 in bits 7:4, the select value in bits 3:1 and the direction in bit 0 (1 = read). The block pulls SDA low during the ninth clock only when bits 7:4 equal 4'b1010 and bits 3:1 equal `sel`. Otherwise it stays silent until the next start or stop.
- R3: While `busy` is high, the block does not acknowledge a matching address byte.
- R4: In a write, the block acknowledges two address bytes, high byte first, and then every data byte. Bits of the 16-bit address above ADDR_W are ignored.
- R5: For each data byte received, `wr_strobe` pulses for exactly one cycle, with `wr_addr` and `wr_data`. The address then advances inside a 2^SEC_W-byte sector: the low SEC_W bits wrap and the upper bits are unchanged.
- R6: `wr_commit` pulses once at the stop that ends a write which delivered at least one data byte. A write that carried only address bytes produces no pulse.
- R7: Read data is driven MSB first. Each bit changes only after SCL falls. The first bit follows the fall that ends the address acknowledge.
- R8: A current-address read returns the byte at the counter. The counter holds the last byte read plus one, or after a write the address after the last byte written (sector-wrapped).
- R9: A random read (a write carrying only the two address bytes, then a repeated start with a read address byte) returns the byte at the given address.
- R10: In a sequential read, each master acknowledge loads the next byte. The counter wraps from 2^ADDR_W-1 to 0.
- R11: A master no-acknowledge ends the read. The block releases SDA and ignores further clocks until a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (acknowledge or a 0 data bit) |
| sel | input | 3 | Strapped select value compared with address bits 3:1 |
| busy | input | 1 | Program buffer busy; suppresses the address acknowledge |
| rd_addr | output | ADDR_W | Current counter, to the array read port |
| rd_data | input | 8 | Array byte at `rd_addr`, combinational |
| wr_strobe | output | 1 | One-cycle pulse per received data byte |
| wr_addr | output | ADDR_W | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle pulse at the stop ending a data write |

## Verification
The address match is swept over every pairing of strap value and addressed select value, then over every wrong device code, so a correct match is told apart from one that ignores either field. A six-byte write that starts four bytes below a sector boundary separates sector wrap from a plain increment and from a full-width carry. Polling right after the commit shows whether `busy` gates the address acknowledge. Reads are tried as current-address, random and a 260-byte sequential run crossing the top of the array. These tell apart a counter that advances per byte, one that wraps at the array size, and one that loses its value between transfers. A clocked byte after a master no-acknowledge, and a stop in the middle of a byte, show whether SDA is really released.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } tws_state_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_AHI,
        RX_ALO,
        RX_DAT
    } rx_kind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } line_evt_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_CODE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/tws_line_mon.sv
module tws_line_mon
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic scl_p;
    logic sda_p;
    logic scl_s;
    logic sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_comb begin
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/tws_addr_ctr.sv
module tws_addr_ctr #(
    parameter int ADDR_W = 12,
    parameter int SEC_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_seq,
    input  logic              inc_sec,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (inc_seq) begin
            q <= q + ADDR_W'(1);
        end else if (inc_sec) begin
            q <= {q[ADDR_W-1:SEC_W], q[SEC_W-1:0] + SEC_W'(1)};
        end
    end

    AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (rst) (inc_seq && !load && q == '1) |=> (q == '0)); // R10
    AST_SECTOR_HOLD: assert property (@(posedge clk) disable iff (rst) (inc_sec && !load && !inc_seq) |=> (q[ADDR_W-1:SEC_W] == $past(q[ADDR_W-1:SEC_W]))); // R5

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SEC_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [2:0]        sel,
    input  logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);

    localparam int BITS = 8;

    line_evt_t   evt;
    tws_state_e  state;
    rx_kind_e    kind;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic        next_tx;
    logic        mack;
    logic        wr_pend;
    logic        byte_done;
    logic        quiet;
    logic        ahi_done;

    logic              ctr_load;
    logic              ctr_inc_seq;
    logic              ctr_inc_sec;
    logic [ADDR_W-1:0] ctr_q;
    logic [ADDR_W-1:0] load_val;

    tws_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    tws_addr_ctr #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (load_val),
        .inc_seq  (ctr_inc_seq),
        .inc_sec  (ctr_inc_sec),
        .q        (ctr_q)
    );

    assign rd_addr   = ctr_q;
    assign quiet     = !evt.start && !evt.stop;
    assign byte_done = evt.scl_fall && (bitcnt == 4'(BITS));
    assign ahi_done  = quiet && (state == ST_RX) && byte_done && (kind == RX_AHI);

    // Upper address bits kept only when the array is wider than one byte.
    generate
        if (ADDR_W > 8) begin : g_hi
            logic [ADDR_W-9:0] hi_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hi_q <= '0;
                end else if (ahi_done) begin
                    hi_q <= shreg[ADDR_W-9:0];
                end
            end
            assign load_val = {hi_q, shreg};
        end else begin : g_nohi
            assign load_val = shreg;
        end
    endgenerate

    always_comb begin
        ctr_load    = 1'b0;
        ctr_inc_seq = 1'b0;
        ctr_inc_sec = 1'b0;
        if (quiet) begin
            case (state)
                ST_RX: begin
                    if (byte_done && kind == RX_ALO) ctr_load = 1'b1;
                    if (byte_done && kind == RX_DAT) ctr_inc_sec = 1'b1;
                end
                ST_RXACK: if (evt.scl_fall && next_tx) ctr_inc_seq = 1'b1;
                ST_TXACK: if (evt.scl_fall && mack) ctr_inc_seq = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            kind      <= RX_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            next_tx   <= 1'b0;
            mack      <= 1'b0;
            wr_pend   <= 1'b0;
            sda_oe    <= 1'b0;
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            wr_commit <= 1'b0;
            if (evt.start) begin
                state  <= ST_RX;
                kind   <= RX_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state     <= ST_IDLE;
                sda_oe    <= 1'b0;
                wr_commit <= wr_pend;
                wr_pend   <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[6:0], evt.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            bitcnt  <= '0;
                            next_tx <= 1'b0;
                            case (kind)
                                RX_DEV: begin
                                    if (dev_match(shreg, sel) && !busy) begin
                                        sda_oe  <= 1'b1;
                                        state   <= ST_RXACK;
                                        next_tx <= shreg[0];
                                        kind    <= RX_AHI;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end
                                RX_AHI: begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_RXACK;
                                    kind   <= RX_ALO;
                                end
                                RX_ALO: begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_RXACK;
                                    kind   <= RX_DAT;
                                end
                                default: begin
                                    sda_oe    <= 1'b1;
                                    state     <= ST_RXACK;
                                    wr_strobe <= 1'b1;
                                    wr_addr   <= ctr_q;
                                    wr_data   <= shreg;
                                    wr_pend   <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_RXACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (next_tx) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            sda_oe <= 1'b0;
                            state  <= ST_TXACK;
                        end else if (evt.scl_fall) begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                    ST_TXACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (mack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> $past(evt.scl_fall)); // R7
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst) (quiet && state == ST_RX && kind == RX_DEV && byte_done && busy) |=> !sda_oe); // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst) evt.stop |=> (state == ST_IDLE && !sda_oe)); // R1
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst) (quiet && state == ST_TXACK && evt.scl_fall && !mack) |=> (state == ST_SKIP && !sda_oe)); // R11
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst) wr_strobe |=> !wr_strobe); // R5
    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (rst) $rose(wr_commit) |-> $past(evt.stop)); // R6

endmodule

// File: tb/tb_tws_slave.sv
module tb_tws_slave;

    localparam int AW = 8;
    localparam int SW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] sel_pins = 3'd0;
    logic busy;
    logic sda_oe;
    logic [AW-1:0] rd_addr;
    logic [7:0] rd_data;
    logic wr_strobe;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;
    logic wr_commit;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    int busy_cnt = 0;
    int commits = 0;
    int log_n = 0;
    logic [7:0] log_a [16];
    logic [7:0] log_d [16];
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    always #2.5 clk = ~clk;

    tws_slave #(.ADDR_W(AW), .SEC_W(SW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .sel(sel_pins), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    assign rd_data = mem[rd_addr];
    assign busy = (busy_cnt != 0);

    always @(posedge clk) begin
        if (rst) busy_cnt <= 0;
        else if (wr_commit) busy_cnt <= 400;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (!rst && wr_strobe) mem[wr_addr] <= wr_data;
    end

    always @(negedge clk) begin
        if (!rst && wr_commit) commits++;
        if (!rst && wr_strobe && log_n < 16) begin
            log_a[log_n] = wr_addr;
            log_d[log_n] = wr_data;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic r);
        scl_m = 1'b0; wclk(4);
        sda_m = b;    wclk(4);
        scl_m = 1'b1; wclk(4);
        r = sda_line; wclk(4);
    endtask

    task automatic do_start();
        scl_m = 1'b0; wclk(4);
        sda_m = 1'b1; wclk(4);
        scl_m = 1'b1; wclk(4);
        sda_m = 1'b0; wclk(4);
    endtask

    task automatic do_stop();
        scl_m = 1'b0; wclk(4);
        sda_m = 1'b0; wclk(4);
        scl_m = 1'b1; wclk(4);
        sda_m = 1'b1; wclk(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_x(b[i], r);
        bit_x(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b1, r);
            d = {d[6:0], r};
        end
        bit_x(~give_ack, r);
    endtask

    function automatic logic [7:0] dev(input logic [2:0] s, input logic rw);
        return {4'b1010, s, rw};
    endfunction

    initial begin
        logic ack;
        logic r;
        logic [7:0] d;
        int tries;
        int ctr;

        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
            ref_mem[i] = mem[i];
        end

        wclk(5);
        rst = 1'b0;
        wclk(2);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1 reset oe", int'(sda_oe), 0);
        chk(wr_strobe == 1'b0 && wr_commit == 1'b0, "R1 reset strobes", int'(wr_strobe), 0);

        // R2: select sweep, every strap against every addressed value
        for (int p = 0; p < 8; p++) begin
            sel_pins = 3'(p);
            for (int a = 0; a < 8; a++) begin
                do_start();
                send_byte(dev(3'(a), 1'b0), ack);
                do_stop();
                chk(ack == (a == p), "R2 select match", int'(ack), int'(a == p));
            end
        end
        // R2: wrong device codes never answered
        sel_pins = 3'd5;
        for (int c = 0; c < 16; c++) begin
            if (c != 10) begin
                do_start();
                send_byte({4'(c), 3'd5, 1'b1}, ack);
                do_stop();
                chk(ack == 1'b0, "R2 device code", int'(ack), 0);
            end
        end

        sel_pins = 3'd2;
        // R4/R5: sector write of six bytes from 0x3C
        do_start();
        send_byte(dev(3'd2, 1'b0), ack);
        chk(ack, "R4 dev ack", int'(ack), 1);
        send_byte(8'h7F, ack);
        chk(ack, "R4 high addr ack", int'(ack), 1);
        send_byte(8'h3C, ack);
        chk(ack, "R4 low addr ack", int'(ack), 1);
        for (int k = 0; k < 6; k++) begin
            send_byte(8'(8'h90 + k * 5), ack);
            chk(ack, "R4 data ack", int'(ack), 1);
            ref_mem[8'h20 | ((8'h3C + k) & 8'h1F)] = 8'(8'h90 + k * 5);
        end
        do_stop();
        chk(sda_oe == 1'b0, "R1 oe after stop", int'(sda_oe), 0);
        chk(log_n == 6, "R5 strobe count", log_n, 6);
        for (int k = 0; k < 6; k++) begin
            chk(log_a[k] == 8'(8'h20 | ((8'h3C + k) & 8'h1F)), "R5 sector addr",
                int'(log_a[k]), 8'h20 | ((8'h3C + k) & 8'h1F));
            chk(log_d[k] == 8'(8'h90 + k * 5), "R5 data", int'(log_d[k]), 8'h90 + k * 5);
        end
        chk(commits == 1, "R6 commit once", commits, 1);

        // R3: address withheld while programming, then polled
        do_start();
        send_byte(dev(3'd2, 1'b0), ack);
        do_stop();
        chk(ack == 1'b0, "R3 busy nack", int'(ack), 0);
        tries = 0;
        ack = 1'b0;
        while (!ack && tries < 20) begin
            tries++;
            do_start();
            send_byte(dev(3'd2, 1'b0), ack);
            do_stop();
        end
        chk(ack == 1'b1, "R3 poll ack", int'(ack), 1);
        chk(tries > 1, "R3 poll tries", tries, 2);
        chk(commits == 1, "R6 no commit address only", commits, 1);

        // R8: current-address reads after the write
        ctr = 8'h22;
        for (int k = 0; k < 2; k++) begin
            do_start();
            send_byte(dev(3'd2, 1'b1), ack);
            recv_byte(1'b0, d);
            do_stop();
            chk(ack && d == ref_mem[ctr], "R8 current read", int'(d), int'(ref_mem[ctr]));
            ctr = (ctr + 1) & 8'hFF;
        end

        // R9/R7: random read of a written byte
        do_start();
        send_byte(dev(3'd2, 1'b0), ack);
        send_byte(8'h00, ack);
        send_byte(8'h3E, ack);
        do_start();
        send_byte(dev(3'd2, 1'b1), ack);
        recv_byte(1'b0, d);
        do_stop();
        chk(d == ref_mem[8'h3E], "R9 R7 random read", int'(d), int'(ref_mem[8'h3E]));
        chk(commits == 1, "R6 dummy write no commit", commits, 1);

        // R10: sequential read crossing the top of the array
        do_start();
        send_byte(dev(3'd2, 1'b0), ack);
        send_byte(8'h00, ack);
        send_byte(8'hF0, ack);
        do_start();
        send_byte(dev(3'd2, 1'b1), ack);
        for (int i = 0; i < 260; i++) begin
            recv_byte(i != 259, d);
            chk(d == ref_mem[(8'hF0 + i) & 8'hFF], "R10 sequential",
                int'(d), int'(ref_mem[(8'hF0 + i) & 8'hFF]));
        end
        do_stop();
        ctr = (8'hF0 + 260) & 8'hFF;
        do_start();
        send_byte(dev(3'd2, 1'b1), ack);
        recv_byte(1'b0, d);
        chk(d == ref_mem[ctr], "R8 after sequential", int'(d), int'(ref_mem[ctr]));
        ctr = (ctr + 1) & 8'hFF;

        // R11: no further drive after master no-acknowledge
        for (int i = 0; i < 9; i++) begin
            bit_x(1'b1, r);
            chk(r == 1'b1, "R11 released", int'(r), 1);
        end
        do_stop();
        chk(sda_oe == 1'b0, "R1 idle after nack", int'(sda_oe), 0);

        // R1: stop in the middle of a byte, counter untouched
        do_start();
        send_byte(dev(3'd2, 1'b0), ack);
        bit_x(1'b0, r);
        bit_x(1'b1, r);
        bit_x(1'b0, r);
        do_stop();
        chk(sda_oe == 1'b0, "R1 mid-byte stop", int'(sda_oe), 0);
        do_start();
        send_byte(dev(3'd2, 1'b1), ack);
        recv_byte(1'b0, d);
        do_stop();
        chk(d == ref_mem[ctr], "R1 R8 read after abort", int'(d), int'(ref_mem[ctr]));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule